// File: doc/BRIEF.md
# Multi-Line D-Channel Upstream Arbiter

This block chooses which of several subscriber D-channels may send upstream. Every line delivers its own serial bit stream with a per-line valid strobe. A small detector on each line finds opening flags, closing flags and abort runs. A four-state controller then hands the single upstream path to one line at a time. Toward every terminal the block reports, one bit per line, whether the upstream path is currently available to it or blocked. The terminal equipment uses that indication to hold back or abort its own transmission.

A frame is granted in the full-selection state. When the frame finishes, the controller may spend a programmable number of octet times in a limited-selection state. In that state the line it has just served cannot win. This keeps one busy terminal from starving the others. A suspend limit decides how many back-to-back frames one line may send before that limited phase is forced. A watchdog drops a grant when the winning line goes silent, so that a failed terminal cannot lock out its neighbours. A bypass input parks the controller and reduces the block to a plain channel selector. In that mode an external echo scheme arbitrates.

Top module: `dch_arbiter`

## Requirements
- R1: After reset, `arb_state` is 0 (full selection; encoding 0 full, 1 limited, 2 expecting data, 3 receiving). `avail` is all ones, `grant` is zero and `up_vld` is low.
- R2: A frame start is an opening flag (octet 0x7E, bits taken most significant first) followed by eight bits that are neither a flag nor an abort. In full selection, the line whose frame start completes in a cycle is granted at that clock edge and the state becomes 2. When several lines start in the same cycle, the lowest index wins.
- R3: While the state is 2 or 3, `grant` is one-hot and `avail` equals `grant`, so every other line reads blocked. `up_bit` and `up_vld` follow the granted line's bit and valid.
- R4: In state 2, the next valid bit of the granted frame moves the state to 3. A closing flag 0x7E on the granted line releases the grant.
- R5: On release, the state becomes 1 when `cfg_dfs` is nonzero and the line's consecutive-frame count exceeds `cfg_susp`. In state 1, `avail` is all ones except for the last-served line, whose frame starts are ignored. Another line's start is granted. With no start, the state returns to 0 after exactly `cfg_dfs`×8 `tick` cycles.
- R6: With `cfg_dfs` equal to 0, a release always goes straight to state 0.
- R7: The consecutive-frame count is 1 for a grant to a line other than the last-served one, and one more than before for the same line. A release whose count is at most `cfg_susp` returns to state 0 and skips state 1.
- R8: A run of seven ones on the granted line inside a frame is an abort. It releases the grant under the same rules as R5 to R7.
- R9: If state 2 sees no data from the granted line for WD_OCT×8 `tick` cycles, the grant is dropped and the state returns to 0.
- R10: With `cfg_bypass` high, the state is held at 0 with no grant and `avail` is all ones. `up_bit` and `up_vld` copy line `cfg_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Bit-time strobe for the phase timer and the watchdog |
| ln_vld | input | N_LINES | Per-line bit valid |
| ln_bit | input | N_LINES | Per-line serial bit, most significant bit of each octet first |
| cfg_dfs | input | DFS_W | Limited-selection length in octet times (0 skips the phase) |
| cfg_susp | input | SUSP_W | Back-to-back frames allowed before the phase is forced |
| cfg_bypass | input | 1 | Park the controller and act as a plain selector |
| cfg_line | input | IDX_W | Line routed upstream in bypass |
| avail | output | N_LINES | Per-line available (1) or blocked (0) |
| grant | output | N_LINES | One-hot granted line |
| arb_state | output | 2 | Controller state |
| up_bit | output | 1 | Upstream bit (1 when idle) |
| up_vld | output | 1 | Upstream bit valid |

## Verification
The bench builds the block with three lines and a watchdog of four octet times; other parameters keep their defaults. Three lines give a line count that is not a power of two. They also make every tie pattern reachable in random rounds, along with a third line that can win while another is excluded. The short watchdog lets the stall timeout, the limited-phase expiry and the exact boundary cycles around both be hit and checked on either side.

// File: rtl/dch_arb_pkg.sv
package dch_arb_pkg;

    typedef enum logic [1:0] {
        ST_FULL   = 2'd0,
        ST_LIMIT  = 2'd1,
        ST_EXPECT = 2'd2,
        ST_RECV   = 2'd3
    } arb_st_e;

    // per-line events produced by the framing detector
    typedef struct packed {
        logic start;
        logic fin;
        logic abort;
        logic data;
    } line_ev_t;

    localparam logic [7:0] FLAG_OCT = 8'h7E;

    function automatic logic [2:0] ones_next(input logic [2:0] c, input logic b);
        if (!b)           return 3'd0;
        else if (c == 3'd7) return 3'd7;
        else              return c + 3'd1;
    endfunction

endpackage

// File: rtl/dch_line_det.sv
module dch_line_det
    import dch_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     vld,
    input  logic     bit_i,
    output line_ev_t ev
);
    logic [7:0] sh;
    logic [2:0] ones;
    logic [2:0] nb;
    logic       fopen;
    logic       infr;
    logic [7:0] nsh;
    logic       is_flag;
    logic       is_abort;

    always_comb begin
        nsh      = {sh[6:0], bit_i};
        is_flag  = vld && (nsh == FLAG_OCT);
        is_abort = vld && bit_i && (ones == 3'd6);
        ev.start = vld && fopen && (nb == 3'd7) && !is_flag && !is_abort;
        ev.fin   = is_flag && infr;
        ev.abort = is_abort && infr;
        ev.data  = vld && infr && !is_flag && !is_abort;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            ones  <= '0;
            nb    <= '0;
            fopen <= 1'b0;
            infr  <= 1'b0;
        end else if (vld) begin
            sh   <= nsh;
            ones <= ones_next(ones, bit_i);
            if (is_abort) begin
                fopen <= 1'b0;
                infr  <= 1'b0;
                nb    <= '0;
            end else if (is_flag) begin
                fopen <= 1'b1;
                infr  <= 1'b0;
                nb    <= '0;
            end else if (ev.start) begin
                fopen <= 1'b0;
                infr  <= 1'b1;
                nb    <= '0;
            end else if (fopen) begin
                nb <= nb + 3'd1;
            end
        end
    end
endmodule

// File: rtl/dch_pick.sv
module dch_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] win
);
    // isolate lowest set bit: fixed priority, index 0 first
    always_comb win = req & (~req + N'(1));
endmodule

// File: rtl/dch_arbiter.sv
module dch_arbiter
    import dch_arb_pkg::*;
#(
    parameter int N_LINES = 4,
    parameter int DFS_W   = 5,
    parameter int SUSP_W  = 3,
    parameter int WD_OCT  = 16,
    localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [N_LINES-1:0] ln_vld,
    input  logic [N_LINES-1:0] ln_bit,
    input  logic [DFS_W-1:0]   cfg_dfs,
    input  logic [SUSP_W-1:0]  cfg_susp,
    input  logic               cfg_bypass,
    input  logic [IDX_W-1:0]   cfg_line,
    output logic [N_LINES-1:0] avail,
    output logic [N_LINES-1:0] grant,
    output logic [1:0]         arb_state,
    output logic               up_bit,
    output logic               up_vld
);
    localparam int TMR_W  = DFS_W + 3;
    localparam int WD_LIM = WD_OCT * 8;
    localparam int WD_W   = $clog2(WD_LIM + 1);

    line_ev_t           ev [N_LINES];
    logic [N_LINES-1:0] st_v, fin_v, ab_v, dat_v;

    for (genvar i = 0; i < N_LINES; i++) begin : g_det
        dch_line_det u_det (
            .clk  (clk),
            .rst  (rst),
            .vld  (ln_vld[i]),
            .bit_i(ln_bit[i]),
            .ev   (ev[i])
        );
        assign st_v[i]  = ev[i].start;
        assign fin_v[i] = ev[i].fin;
        assign ab_v[i]  = ev[i].abort;
        assign dat_v[i] = ev[i].data;
    end

    arb_st_e            st;
    logic [N_LINES-1:0] last_oh;
    logic [IDX_W-1:0]   gidx;
    logic [SUSP_W-1:0]  cnt;
    logic [TMR_W-1:0]   tmr;
    logic [WD_W-1:0]    wd;

    logic [N_LINES-1:0] cand, win_oh;
    logic               g_end, g_data, to_limit, busy;
    logic [SUSP_W-1:0]  cnt_win;

    function automatic logic [IDX_W-1:0] idx_of(input logic [N_LINES-1:0] oh);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int k = 0; k < N_LINES; k++)
            if (oh[k]) r = IDX_W'(k);
        return r;
    endfunction

    always_comb begin
        cand     = st_v & ((st == ST_LIMIT) ? ~last_oh : '1);
        g_end    = |((fin_v | ab_v) & grant);
        g_data   = |(dat_v & grant);
        to_limit = (cfg_dfs != '0) && (cnt > cfg_susp);
        cnt_win  = (win_oh == last_oh) ? ((cnt == '1) ? cnt : cnt + SUSP_W'(1))
                                       : SUSP_W'(1);
        busy     = (st == ST_EXPECT) || (st == ST_RECV);
    end

    dch_pick #(.N(N_LINES)) u_pick (
        .req(cand),
        .win(win_oh)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_FULL;
            grant   <= '0;
            last_oh <= '0;
            gidx    <= '0;
            cnt     <= '0;
            tmr     <= '0;
            wd      <= '0;
        end else if (cfg_bypass) begin
            st    <= ST_FULL;
            grant <= '0;
            wd    <= '0;
        end else begin
            unique case (st)
                ST_FULL, ST_LIMIT: begin
                    if (cand != '0) begin
                        st      <= ST_EXPECT;
                        grant   <= win_oh;
                        gidx    <= idx_of(win_oh);
                        last_oh <= win_oh;
                        cnt     <= cnt_win;
                        wd      <= '0;
                    end else if (st == ST_LIMIT && tick) begin
                        if (tmr <= TMR_W'(1)) st <= ST_FULL;
                        else                  tmr <= tmr - TMR_W'(1);
                    end
                end
                ST_EXPECT, ST_RECV: begin
                    if (g_end) begin
                        grant <= '0;
                        if (to_limit) begin
                            st  <= ST_LIMIT;
                            tmr <= {cfg_dfs, 3'b000};
                            cnt <= '0;
                        end else begin
                            st <= ST_FULL;
                        end
                    end else if (st == ST_EXPECT) begin
                        if (g_data) begin
                            st <= ST_RECV;
                        end else if (tick) begin
                            if (wd == WD_W'(WD_LIM - 1)) begin
                                st    <= ST_FULL;
                                grant <= '0;
                            end else begin
                                wd <= wd + WD_W'(1);
                            end
                        end
                    end
                end
                default: st <= ST_FULL;
            endcase
        end
    end

    always_comb begin
        arb_state = st;
        if (cfg_bypass || st == ST_FULL) avail = '1;
        else if (st == ST_LIMIT)         avail = ~last_oh;
        else                             avail = grant;
        if (cfg_bypass) begin
            up_bit = ln_bit[cfg_line];
            up_vld = ln_vld[cfg_line];
        end else if (busy) begin
            up_bit = ln_bit[gidx];
            up_vld = ln_vld[gidx];
        end else begin
            up_bit = 1'b1;
            up_vld = 1'b0;
        end
    end
endmodule

// File: rtl/dch_arbiter_chk.sv
module dch_arbiter_chk #(
    parameter int N_LINES = 4,
    parameter int DFS_W   = 5
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         arb_state,
    input logic [N_LINES-1:0] grant,
    input logic [N_LINES-1:0] avail,
    input logic [DFS_W-1:0]   cfg_dfs,
    input logic               cfg_bypass
);
    logic busy;
    assign busy = arb_state[1];

    // R3: a busy state owns exactly one line and blocks the rest
    p_busy_grant_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($onehot(grant) && avail == grant));

    // R3: no grant outside the busy states
    p_idle_nogrant_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> grant == '0);

    // R2: expecting state is entered only from a selection state
    p_expect_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (arb_state == 2'd2 && $past(arb_state) != 2'd2) |-> !$past(arb_state[1]));

    // R5: limited phase only follows a served frame
    p_limit_entry_r5: assert property (@(posedge clk) disable iff (rst)
        (arb_state == 2'd1 && $past(arb_state) != 2'd1) |-> $past(arb_state[1]));

    // R6: a zero delay never opens a limited phase
    p_limit_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (arb_state == 2'd1 && $past(arb_state) != 2'd1) |-> $past(cfg_dfs) != '0);

    // R10: bypass parks the controller
    p_bypass_park_r10: assert property (@(posedge clk) disable iff (rst)
        cfg_bypass |=> (arb_state == 2'd0 && grant == '0));
endmodule

bind dch_arbiter dch_arbiter_chk #(.N_LINES(N_LINES), .DFS_W(DFS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .arb_state (arb_state),
    .grant     (grant),
    .avail     (avail),
    .cfg_dfs   (cfg_dfs),
    .cfg_bypass(cfg_bypass)
);

// File: tb/dch_arbiter_tb.sv
`timescale 1ns/1ps
module dch_arbiter_tb;
    localparam int N  = 3;
    localparam int WD = 4;
    localparam logic [7:0] FL = 8'h7E;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b1;
    logic [N-1:0] ln_vld = '0;
    logic [N-1:0] ln_bit = '1;
    logic [4:0]   cfg_dfs = 5'd3;
    logic [2:0]   cfg_susp = 3'd0;
    logic         cfg_bypass = 1'b0;
    logic [1:0]   cfg_line = 2'd0;
    logic [N-1:0] avail, grant;
    logic [1:0]   arb_state;
    logic         up_bit, up_vld;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dch_arbiter #(.N_LINES(N), .WD_OCT(WD)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .ln_vld(ln_vld), .ln_bit(ln_bit),
        .cfg_dfs(cfg_dfs), .cfg_susp(cfg_susp), .cfg_bypass(cfg_bypass),
        .cfg_line(cfg_line), .avail(avail), .grant(grant),
        .arb_state(arb_state), .up_bit(up_bit), .up_vld(up_vld)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dat();
        return 8'($urandom) & 8'h5A;
    endfunction

    function automatic logic [N-1:0] lowest(input logic [N-1:0] r);
        for (int k = 0; k < N; k++)
            if (r[k]) return N'(1) << k;
        return '0;
    endfunction

    // one octet per line, MSB first; octets packed {l2,l1,l0}
    task automatic send(input logic [N*8-1:0] o);
        for (int b = 7; b >= 0; b--) begin
            for (int i = 0; i < N; i++) ln_bit[i] = o[i*8+b];
            ln_vld = '1;
            @(negedge clk);
        end
        ln_vld = '0;
    endtask

    task automatic flags();
        send({FL, FL, FL});
    endtask

    task automatic idle(input int n);
        ln_vld = '0;
        repeat (n) @(negedge clk);
    endtask

    task automatic st_chk(input string req, input logic [1:0] s, input logic [N-1:0] g);
        chk(req, 32'(arb_state), 32'(s));
        chk(req, 32'(grant), 32'(g));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        st_chk("R1", 2'd0, 3'b000);
        chk("R1 avail", 32'(avail), 32'h7);
        chk("R1 up_vld", 32'(up_vld), 0);

        // R2 tie between lines 1 and 2: line 1 wins; R3 others blocked
        flags(); flags();
        send({dat(), dat(), FL});
        st_chk("R2 tie", 2'd2, 3'b010);
        chk("R3 avail", 32'(avail), 32'h2);
        // R4 next data moves to receive
        send({dat(), dat(), FL});
        st_chk("R4 recv", 2'd3, 3'b010);
        // R3 upstream follows granted line
        ln_bit = 3'b010; ln_vld = 3'b111;
        #1;
        chk("R3 up_bit", 32'(up_bit), 1);
        chk("R3 up_vld", 32'(up_vld), 1);
        @(negedge clk);
        ln_vld = '0;
        // R4/R5 closing flag releases into limited phase
        flags();
        st_chk("R5 enter", 2'd1, 3'b000);
        chk("R5 avail", 32'(avail), 32'h5);
        // R5 last-served line 1 is ignored
        send({FL, dat(), FL});
        st_chk("R5 excl", 2'd1, 3'b000);
        // R5 another line wins inside the phase
        send({FL, FL, dat()});
        st_chk("R5 other", 2'd2, 3'b001);
        // R9 watchdog on silent line 0
        idle(WD * 8 - 1);
        st_chk("R9 before", 2'd2, 3'b001);
        idle(1);
        st_chk("R9 expire", 2'd0, 3'b000);
        flags(); flags();
        st_chk("R9 after", 2'd0, 3'b000);

        // R5 phase expiry after cfg_dfs*8 ticks
        send({dat(), FL, FL});
        st_chk("R2 single", 2'd2, 3'b100);
        flags();
        st_chk("R5 enter2", 2'd1, 3'b000);
        idle(23);
        chk("R5 hold", 32'(arb_state), 1);
        idle(1);
        chk("R5 expire", 32'(arb_state), 0);

        // R6 zero delay skips limited phase
        cfg_dfs = 5'd0;
        flags();
        send({FL, FL, dat()});
        send({FL, FL, dat()});
        st_chk("R6 recv", 2'd3, 3'b001);
        flags();
        st_chk("R6 release", 2'd0, 3'b000);

        // R8 abort on granted line 2
        flags();
        send({dat(), FL, FL});
        send({dat(), FL, FL});
        st_chk("R8 recv", 2'd3, 3'b100);
        send({8'hFF, FL, FL});
        st_chk("R8 abort", 2'd0, 3'b000);
        chk("R8 avail", 32'(avail), 32'h7);
        flags(); flags();

        // R7 suspend limit 1: first frame back to full, second forces phase
        cfg_dfs = 5'd3; cfg_susp = 3'd1;
        send({FL, FL, dat()});
        send({FL, FL, dat()});
        flags();
        st_chk("R7 first", 2'd0, 3'b000);
        send({FL, FL, dat()});
        st_chk("R7 again", 2'd2, 3'b001);
        send({FL, FL, dat()});
        flags();
        st_chk("R7 second", 2'd1, 3'b000);
        idle(24);
        chk("R7 back", 32'(arb_state), 0);

        // R10 bypass routes chosen line
        cfg_bypass = 1'b1; cfg_line = 2'd2;
        ln_bit = 3'b011; ln_vld = 3'b100;
        #1;
        chk("R10 bit0", 32'(up_bit), 0);
        chk("R10 vld", 32'(up_vld), 1);
        ln_bit = 3'b100;
        #1;
        chk("R10 bit1", 32'(up_bit), 1);
        @(negedge clk);
        flags();
        send({FL, FL, dat()});
        st_chk("R10 park", 2'd0, 3'b000);
        chk("R10 avail", 32'(avail), 32'h7);
        cfg_bypass = 1'b0;
        flags(); flags();

        // R2 random start patterns, lowest index wins
        cfg_dfs = 5'd0;
        for (int k = 0; k < 20; k++) begin
            logic [N-1:0] req;
            logic [N*8-1:0] o;
            req = N'($urandom_range(1, 7));
            for (int i = 0; i < N; i++) o[i*8+:8] = req[i] ? dat() : FL;
            send(o);
            st_chk("R2 rand", 2'd2, lowest(req));
            for (int i = 0; i < N; i++) o[i*8+:8] = req[i] ? dat() : FL;
            send(o);
            chk("R4 rand", 32'(arb_state), 3);
            flags();
            st_chk("R6 rand", 2'd0, 3'b000);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule